// File: doc/BRIEF.md
# Serial EEPROM Write-Protection Controller

This block sits beside the serial slave engine of a 256-byte EEPROM and decides which incoming data bytes may reach the array. It combines two locks. The first is a write-protect pin that freezes every byte while it is high. The second is a permanent lock flag that, once set, freezes the lower half (00h–7Fh) whatever the pin level. The permanent lock is set by a one-time software command. That command is refused whenever the pin is high.

The engine hands the block decoded bus events: a received slave-address byte (device nibble and R/W bit), a word-address byte, each data byte, Start and Stop. The programming timer returns a completion strobe. From these the block produces four things: a per-byte write enable with its target address, a pulse that starts a programming cycle, a busy level that lasts until that cycle completes, and the decision whether the engine acknowledges the protection device nibble 0110.

The permanent flag survives the soft reset `rst` and is cleared only by the power-on reset `por`. Both resets are synchronous and active high. A write-protect pin left unconnected is expected to be pulled low on the board, which makes it behave as low.

Top module: `eewp_ctrl`

## Requirements
- R1: While `wp_pin` is high at the edge where a data byte arrives, `wr_en` stays low for that byte, at any address 00h–FFh.
- R2: While `perm_lock` is 1, data bytes for addresses with bit 7 = 0 (00h–7Fh) give no `wr_en`. Bytes for addresses with bit 7 = 1 (80h–FFh) still give `wr_en` while `wp_pin` is low.
- R3: A normal write uses device nibble 1010 with R/W = 0. For such a write, `wr_en` pulses for one cycle in the cycle after an allowed data byte, with `wr_addr` equal to the internal pointer. The pointer loads from the word-address byte. After each data byte, its low 4 bits count up and wrap within the 16-byte page, and the high 4 bits stay unchanged.
- R4: The lock command is nibble 0110 with R/W = 0, then a dummy word address, a dummy data byte and a Stop. At that Stop, `prog_start` pulses and `busy` rises. `perm_lock` becomes 1 one cycle after `prog_done`, and not before. A Start that arrives before the Stop abandons the command, and nothing changes. The dummy bytes never give `wr_en`.
- R5: If `wp_pin` is high at the Stop of the lock command, no programming cycle starts and `perm_lock` stays 0.
- R6: `prot_ack` pulses for one cycle in the cycle after a slave-address byte with nibble 0110. It is 1 only when `perm_lock` is 0 and `busy` is 0, for both R/W values. A 0110 address with R/W = 1 changes no state.
- R7: A Stop that ends a normal write with at least one enabled byte pulses `prog_start` and raises `busy` until `prog_done`. While `busy` is 1, no `prot_ack` and no `wr_en` are produced.
- R8: A normal write whose bytes were all blocked is still acknowledged by the engine. Its Stop pulses no `prog_start` and leaves `busy` at 0.
- R9: `rst` clears `busy`, `wr_en`, `prog_start` and `prot_ack` but keeps `perm_lock`. `por` clears everything, including `perm_lock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous soft reset, keeps the permanent flag |
| por | input | 1 | Synchronous power-on reset, clears everything |
| wp_pin | input | 1 | Write-protect pin, high locks the whole array |
| sa_valid | input | 1 | Slave-address byte received (address pins already matched) |
| sa_code | input | 4 | Device nibble of that byte |
| sa_rw | input | 1 | R/W bit of that byte, 1 = read |
| wa_valid | input | 1 | Word-address byte received |
| wa_addr | input | 8 | Word-address byte value |
| wd_valid | input | 1 | Data byte received in a write |
| start_seen | input | 1 | Start condition seen |
| stop_seen | input | 1 | Stop condition seen |
| prog_done | input | 1 | Programming cycle finished |
| prot_ack | output | 1 | Acknowledge the 0110 device nibble |
| wr_en | output | 1 | Per-byte write enable into the page buffer |
| wr_addr | output | 8 | Address for `wr_en` |
| prog_start | output | 1 | Start the programming cycle |
| busy | output | 1 | Programming cycle in progress |
| perm_lock | output | 1 | Permanent lower-half lock flag |

## Verification
The bench walks one table of pin levels and addresses twice, once before the lock and once after. An off-by-one on the half boundary would open 7Fh or close 80h. A design that honoured only one lock would let through a byte the other lock should stop. It drives page writes across the 9Fh→90h wrap, which catches a pointer that carries into the high bits. It also covers the lock command aborted by a Start, the lock command with the pin raised at its Stop, and the flag seen before `prog_done`. A design that set the flag early or on a partial sequence would fail these. Finally it checks that `rst` keeps the flag while `por` clears it, and that a write with only blocked bytes starts no programming cycle.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_NW_ADDR,
    SQ_NW_DATA,
    SQ_PR_ADDR,
    SQ_PR_DATA,
    SQ_PR_STOP
  } seq_e;
endpackage

// File: rtl/eewp_seq.sv
module eewp_seq
  import eewp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int CODE_W    = 4,
  parameter logic [CODE_W-1:0] DEV_CODE  = 4'b1010,
  parameter logic [CODE_W-1:0] PROT_CODE = 4'b0110
) (
  input  logic              clk,
  input  logic              rst_any,
  input  logic              busy,
  input  logic              perm_lock,
  input  logic              sa_valid,
  input  logic [CODE_W-1:0] sa_code,
  input  logic              sa_rw,
  input  logic              wa_valid,
  input  logic [ADDR_W-1:0] wa_addr,
  input  logic              wd_valid,
  input  logic              start_seen,
  input  logic              stop_seen,
  output logic              txn_begin,
  output logic              byte_evt,
  output logic [ADDR_W-1:0] byte_addr,
  output logic              norm_stop,
  output logic              prot_stop,
  output logic              prot_ack
);
  localparam int HI_W = ADDR_W - PAGE_W;
  localparam logic [PAGE_W-1:0] ONE = {{(PAGE_W-1){1'b0}}, 1'b1};

  seq_e              st;
  logic [ADDR_W-1:0] ptr;

  // decoded events, valid only while idle of programming
  always_comb begin
    txn_begin = !busy && sa_valid && (sa_code == DEV_CODE) && !sa_rw;
    byte_evt  = !busy && wd_valid && (st == SQ_NW_DATA);
    byte_addr = ptr;
    norm_stop = !busy && stop_seen && (st == SQ_NW_DATA);
    prot_stop = !busy && stop_seen && (st == SQ_PR_STOP);
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      st       <= SQ_IDLE;
      ptr      <= '0;
      prot_ack <= 1'b0;
    end else if (busy) begin
      st       <= SQ_IDLE;
      prot_ack <= 1'b0;
    end else begin
      prot_ack <= sa_valid && (sa_code == PROT_CODE) && !perm_lock;
      if (start_seen || stop_seen) begin
        st <= SQ_IDLE;
      end else begin
        unique case (st)
          SQ_IDLE: ;
          SQ_NW_ADDR:
            if (wa_valid) begin
              ptr <= wa_addr;
              st  <= SQ_NW_DATA;
            end
          SQ_NW_DATA:
            if (wd_valid) ptr <= {ptr[ADDR_W-1 -: HI_W], ptr[PAGE_W-1:0] + ONE};
          SQ_PR_ADDR: if (wa_valid) st <= SQ_PR_DATA;
          SQ_PR_DATA: if (wd_valid) st <= SQ_PR_STOP;
          SQ_PR_STOP: ;
          default:    st <= SQ_IDLE;
        endcase
        if (sa_valid) begin
          if (txn_begin)
            st <= SQ_NW_ADDR;
          else if ((sa_code == PROT_CODE) && !sa_rw && !perm_lock)
            st <= SQ_PR_ADDR;
          else
            st <= SQ_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/eewp_gate.sv
module eewp_gate #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_any,
  input  logic              wp_pin,
  input  logic              perm_lock,
  input  logic              txn_begin,
  input  logic              byte_evt,
  input  logic [ADDR_W-1:0] byte_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              any_en
);
  localparam int TOP = ADDR_W - 1;

  logic lower_half;
  logic allowed;

  always_comb begin
    lower_half = !byte_addr[TOP];
    allowed    = !wp_pin && !(perm_lock && lower_half);
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      any_en  <= 1'b0;
    end else begin
      wr_en <= byte_evt && allowed;
      if (byte_evt) wr_addr <= byte_addr;
      if (txn_begin)
        any_en <= 1'b0;
      else if (byte_evt && allowed)
        any_en <= 1'b1;
    end
  end
endmodule

// File: rtl/eewp_lock.sv
module eewp_lock (
  input  logic clk,
  input  logic rst,
  input  logic por,
  input  logic wp_pin,
  input  logic norm_stop,
  input  logic prot_stop,
  input  logic any_en,
  input  logic prog_done,
  output logic prog_start,
  output logic busy,
  output logic perm_lock
);
  logic lock_pend;

  always_ff @(posedge clk) begin
    if (por) begin
      prog_start <= 1'b0;
      busy       <= 1'b0;
      lock_pend  <= 1'b0;
      perm_lock  <= 1'b0;
    end else if (rst) begin
      prog_start <= 1'b0;
      busy       <= 1'b0;
      lock_pend  <= 1'b0;
    end else begin
      prog_start <= 1'b0;
      if (busy) begin
        if (prog_done) begin
          busy      <= 1'b0;
          lock_pend <= 1'b0;
          if (lock_pend) perm_lock <= 1'b1;
        end
      end else if (norm_stop && any_en) begin
        prog_start <= 1'b1;
        busy       <= 1'b1;
      end else if (prot_stop && !wp_pin) begin
        prog_start <= 1'b1;
        busy       <= 1'b1;
        lock_pend  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eewp_ctrl.sv
module eewp_ctrl #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              wp_pin,
  input  logic              sa_valid,
  input  logic [CODE_W-1:0] sa_code,
  input  logic              sa_rw,
  input  logic              wa_valid,
  input  logic [ADDR_W-1:0] wa_addr,
  input  logic              wd_valid,
  input  logic              start_seen,
  input  logic              stop_seen,
  input  logic              prog_done,
  output logic              prot_ack,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              prog_start,
  output logic              busy,
  output logic              perm_lock
);
  logic              rst_any;
  logic              txn_begin;
  logic              byte_evt;
  logic [ADDR_W-1:0] byte_addr;
  logic              norm_stop;
  logic              prot_stop;
  logic              any_en;

  assign rst_any = rst || por;

  eewp_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CODE_W(CODE_W)) u_seq (
    .clk        (clk),
    .rst_any    (rst_any),
    .busy       (busy),
    .perm_lock  (perm_lock),
    .sa_valid   (sa_valid),
    .sa_code    (sa_code),
    .sa_rw      (sa_rw),
    .wa_valid   (wa_valid),
    .wa_addr    (wa_addr),
    .wd_valid   (wd_valid),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .txn_begin  (txn_begin),
    .byte_evt   (byte_evt),
    .byte_addr  (byte_addr),
    .norm_stop  (norm_stop),
    .prot_stop  (prot_stop),
    .prot_ack   (prot_ack)
  );

  eewp_gate #(.ADDR_W(ADDR_W)) u_gate (
    .clk       (clk),
    .rst_any   (rst_any),
    .wp_pin    (wp_pin),
    .perm_lock (perm_lock),
    .txn_begin (txn_begin),
    .byte_evt  (byte_evt),
    .byte_addr (byte_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .any_en    (any_en)
  );

  eewp_lock u_lock (
    .clk        (clk),
    .rst        (rst),
    .por        (por),
    .wp_pin     (wp_pin),
    .norm_stop  (norm_stop),
    .prot_stop  (prot_stop),
    .any_en     (any_en),
    .prog_done  (prog_done),
    .prog_start (prog_start),
    .busy       (busy),
    .perm_lock  (perm_lock)
  );
endmodule

// File: rtl/eewp_ctrl_chk.sv
module eewp_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              por,
  input logic              wp_pin,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              prot_ack,
  input logic              prog_start,
  input logic              prog_done,
  input logic              busy,
  input logic              perm_lock
);
  // R1
  pin_lock_chk: assert property (@(posedge clk) disable iff (rst || por)
    wp_pin |=> !wr_en);

  // R2
  lower_half_chk: assert property (@(posedge clk) disable iff (rst || por)
    (perm_lock && wr_en) |-> wr_addr[ADDR_W-1]);

  // R4
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst || por)
    $rose(perm_lock) |-> ($past(prog_done) && $past(busy)));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (por)
    perm_lock |=> perm_lock);

  // R6
  locked_nak_chk: assert property (@(posedge clk) disable iff (rst || por)
    perm_lock |=> !prot_ack);

  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst || por)
    busy |=> (!prot_ack && !wr_en));

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (rst || por)
    prog_start |-> busy);
endmodule

bind eewp_ctrl eewp_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .por        (por),
  .wp_pin     (wp_pin),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .prot_ack   (prot_ack),
  .prog_start (prog_start),
  .prog_done  (prog_done),
  .busy       (busy),
  .perm_lock  (perm_lock)
);

// File: tb/sim_eewp_ctrl.sv
module sim_eewp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam logic [8:0] VEC [0:7] = '{9'h000, 9'h100, 9'h07F, 9'h180,
                                       9'h080, 9'h0FF, 9'h1FF, 9'h040};

  logic       clk = 1'b0;
  logic       rst = 1'b1, por = 1'b1, wp_pin = 1'b0;
  logic       sa_valid = 1'b0, sa_rw = 1'b0, wa_valid = 1'b0, wd_valid = 1'b0;
  logic [3:0] sa_code = '0;
  logic [7:0] wa_addr = '0;
  logic       start_seen = 1'b0, stop_seen = 1'b0, prog_done = 1'b0;
  logic       prot_ack, wr_en, prog_start, busy, perm_lock;
  logic [7:0] wr_addr;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eewp_ctrl u0 (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic sa(input logic [3:0] code, input logic rw);
    sa_code = code; sa_rw = rw; sa_valid = 1'b1;
    @(negedge clk); sa_valid = 1'b0;
  endtask

  task automatic wa(input logic [7:0] a);
    wa_addr = a; wa_valid = 1'b1;
    @(negedge clk); wa_valid = 1'b0;
  endtask

  task automatic wd();
    wd_valid = 1'b1;
    @(negedge clk); wd_valid = 1'b0;
  endtask

  task automatic stp();
    stop_seen = 1'b1;
    @(negedge clk); stop_seen = 1'b0;
  endtask

  task automatic done();
    prog_done = 1'b1;
    @(negedge clk); prog_done = 1'b0;
  endtask

  task automatic write_one(input logic wp, input logic [7:0] a, input logic lk);
    logic exp;
    exp = !wp && !(lk && !a[7]);
    wp_pin = wp;
    sa(4'b1010, 1'b0);
    wa(a);
    wd();
    chk({7'd0, wr_en}, {7'd0, exp}, $sformatf("R1/R2 wr_en wp=%0b addr=%0h", wp, a));
    if (exp) chk(wr_addr, a, "R3 wr_addr");
    stp();
    chk({7'd0, prog_start}, {7'd0, exp}, "R7/R8 prog_start");
    chk({7'd0, busy}, {7'd0, exp}, "R7/R8 busy");
    if (exp) begin
      done();
      chk({7'd0, busy}, 8'd0, "R7 busy after done");
    end
    wp_pin = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0; por = 1'b0;
    // R9 reset state
    chk({3'd0, wr_en, prot_ack, prog_start, busy, perm_lock}, 8'd0, "R9 reset outputs");

    // table walk, flag clear: R1 R2 R8
    for (int i = 0; i < 8; i++) write_one(VEC[i][8], VEC[i][7:0], 1'b0);

    // R3 page wrap 9E,9F,90
    sa(4'b1010, 1'b0); wa(8'h9E);
    wd(); chk(wr_addr, 8'h9E, "R3 page byte0");
    wd(); chk(wr_addr, 8'h9F, "R3 page byte1");
    wd(); chk(wr_addr, 8'h90, "R3 page wrap");
    chk({7'd0, wr_en}, 8'd1, "R3 wr_en pulse");
    @(negedge clk); chk({7'd0, wr_en}, 8'd0, "R3 wr_en one cycle");
    stp();
    chk({7'd0, prog_start}, 8'd1, "R7 prog_start page");
    // R7 busy blocks ack
    sa(4'b0110, 1'b1);
    chk({7'd0, prot_ack}, 8'd0, "R7 no ack while busy");
    done();

    // R6 status query with flag clear
    sa(4'b0110, 1'b1);
    chk({7'd0, prot_ack}, 8'd1, "R6 query ack");
    stp();
    chk({6'd0, prog_start, perm_lock}, 8'd0, "R6 query no change");

    // R5 command with pin high at stop
    sa(4'b0110, 1'b0); chk({7'd0, prot_ack}, 8'd1, "R6 cmd ack");
    wa(8'h00); wd();
    chk({7'd0, wr_en}, 8'd0, "R4 dummy byte no wr_en");
    wp_pin = 1'b1; stp(); wp_pin = 1'b0;
    chk({6'd0, prog_start, perm_lock}, 8'd0, "R5 pin high refuses lock");

    // R4 command broken by start
    sa(4'b0110, 1'b0); wa(8'h00); wd();
    start_seen = 1'b1; @(negedge clk); start_seen = 1'b0;
    stp();
    chk({6'd0, prog_start, perm_lock}, 8'd0, "R4 aborted command");

    // R4 full command
    sa(4'b0110, 1'b0); wa(8'h00); wd(); stp();
    chk({6'd0, prog_start, busy}, 8'd3, "R4 programming started");
    chk({7'd0, perm_lock}, 8'd0, "R4 flag not before done");
    @(negedge clk);
    chk({7'd0, perm_lock}, 8'd0, "R4 flag still waiting");
    done();
    chk({7'd0, perm_lock}, 8'd1, "R4 flag after done");

    // R6 locked: no ack either way
    sa(4'b0110, 1'b1); chk({7'd0, prot_ack}, 8'd0, "R6 locked query nak");
    sa(4'b0110, 1'b0); chk({7'd0, prot_ack}, 8'd0, "R6 locked cmd nak");
    stp();

    // table walk, flag set: R1 R2
    for (int i = 0; i < 8; i++) write_one(VEC[i][8], VEC[i][7:0], 1'b1);

    // R9 soft reset keeps flag, por clears
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk({7'd0, perm_lock}, 8'd1, "R9 rst keeps flag");
    por = 1'b1; @(negedge clk); por = 1'b0;
    chk({7'd0, perm_lock}, 8'd0, "R9 por clears flag");
    write_one(1'b0, 8'h10, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule